// File: doc/BRIEF.md
# Subcarrier Edge-Counting Bit Receiver

This block recovers a short reply that a tag sends back to a reader after a reader frame. The reply arrives as a digital level, already thresholded with hysteresis from the demodulated envelope. A bit is signalled by the presence or absence of a load-modulation subcarrier. The block does not try to lock onto that subcarrier. It cuts time into fixed windows and counts how often the level changes inside each one. A window with a moderate number of changes holds a 1. A quiet window or a noisy window holds a 0.

The reply carries no start marker, stop marker or length field. The windows are therefore placed purely by time, counted from a start pulse that the transmitter raises when its frame ends. The caller says how many bits to expect. A stream of zeros looks exactly like an absent tag. All timing advances on a tick enable rather than on every clock, so one timebase can be shared with the transmitter. When reception ends, the block pulses a request to clear that shared timer. This lets the next reader frame be aligned to it.

Top module: `sc_edge_rx`

## Requirements
- R1: After reset, data_o, nbits_o, done_o and timer_clr_o are all zero.
- R2: The first bit window opens WAIT_TICKS ticks after start_i is sampled. Each window lasts BIT_TICKS ticks, and the windows follow one another with no gap. done_o is high in the clock cycle after the tick that closes the last window, which is the (WAIT_TICKS + N*BIT_TICKS)-th tick after start.
- R3: Every change in the level of the two-stage-synchronized rx_i, seen on a clock cycle while a window is open, counts as one edge of that window.
- R4: A window decodes as 1 when its edge count is strictly greater than EDGE_LO and strictly less than EDGE_HI. Any other count decodes as 0.
- R5: The bit from window k (counting from 0) is written to data_o[k], so the data is least significant bit first. Bits above the received count stay 0.
- R6: A requested bit count above MAX_BITS is clamped to MAX_BITS. nbits_o shows the clamped count from the cycle after start onward.
- R7: The per-window edge counter is EW = clog2(EDGE_HI+1) bits wide and saturates at 2^EW-1 rather than wrapping. An excessive number of edges therefore always decodes as 0.
- R8: data_o reads zero in the cycle after start_i.
- R9: timer_clr_o pulses in the same cycle as done_o.
- R10: done_o is high for exactly one cycle. A request of zero bits completes WAIT_TICKS ticks after start, with data_o equal to zero.
- R11: Window timing advances only on cycles where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Thresholded receive level, asynchronous |
| tick_i | input | 1 | Timebase enable |
| start_i | input | 1 | Single-cycle pulse marking the end of the reader frame |
| nbits_i | input | NB_IN_W | Number of bits to receive |
| data_o | output | MAX_BITS | Received word, least significant bit first |
| nbits_o | output | clog2(MAX_BITS+1) | Clamped bit count of the current or last reception |
| done_o | output | 1 | One-cycle pulse after the final window |
| timer_clr_o | output | 1 | Request to clear the shared frame timer |

## Verification
The bench builds the block with WAIT_TICKS=20, BIT_TICKS=16, EDGE_LO=2 and EDGE_HI=7. These values make the edge counter 3 bits wide. With 16-cycle windows, a burst of 12 or 13 edges fits inside one window. That is enough to overrun the counter: if it wrapped, the burst would decode as 1, while the saturating counter must decode it as 0. The small thresholds also put the counts at both edges of the decision band (2, 3, 6 and 7) within easy reach. The short windows keep a fully clamped 16-bit reception, and a slowed tick rate, down to a few hundred cycles.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_BIT  = 2'd2
  } phase_e;
endpackage

// File: rtl/sc_rx_sync.sv
// Two-flop synchronizer plus level-change detector.
module sc_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q ^ s3_q;
endmodule

// File: rtl/sc_rx_timer.sv
// Wait phase then back-to-back bit windows, all paced by tick_i.
module sc_rx_timer
  import sc_rx_pkg::*;
#(
  parameter int unsigned WAIT_TICKS = 490,
  parameter int unsigned BIT_TICKS  = 150,
  parameter int unsigned MAX_BITS   = 16,
  localparam int unsigned SPAN = (WAIT_TICKS > BIT_TICKS) ? WAIT_TICKS : BIT_TICKS,
  localparam int unsigned TW   = $clog2(SPAN + 1),
  localparam int unsigned IW   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1,
  localparam int unsigned NO_W = $clog2(MAX_BITS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic [NO_W-1:0] req_i,
  output logic            win_o,
  output logic            close_o,
  output logic            fin_o,
  output logic            busy_o,
  output logic [IW-1:0]   idx_o
);
  phase_e          ph_q, ph_d;
  logic [TW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [NO_W-1:0] req_q;
  logic            wait_end, bit_end, last_bit;

  assign wait_end = (ph_q == PH_WAIT) && tick_i && (cnt_q == TW'(WAIT_TICKS - 1));
  assign bit_end  = (ph_q == PH_BIT)  && tick_i && (cnt_q == TW'(BIT_TICKS - 1));
  assign last_bit = (NO_W'(idx_q) + NO_W'(1)) == req_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (start_i) begin
      ph_d  = PH_WAIT;
      cnt_d = '0;
      idx_d = '0;
    end else if (tick_i && ph_q != PH_IDLE) begin
      if (wait_end) begin
        cnt_d = '0;
        ph_d  = (req_q == '0) ? PH_IDLE : PH_BIT;
      end else if (bit_end) begin
        cnt_d = '0;
        if (last_bit) ph_d = PH_IDLE;
        else          idx_d = idx_q + IW'(1);
      end else begin
        cnt_d = cnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      req_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      if (start_i) req_q <= req_i;
    end
  end

  assign win_o   = (ph_q == PH_BIT);
  assign close_o = bit_end && !start_i;
  assign fin_o   = !start_i && ((wait_end && req_q == '0) || (bit_end && last_bit));
  assign busy_o  = (ph_q != PH_IDLE);
  assign idx_o   = idx_q;
endmodule

// File: rtl/sc_rx_edge_cnt.sv
// Saturating per-window edge counter and band decision.
module sc_rx_edge_cnt #(
  parameter int unsigned EDGE_LO = 20,
  parameter int unsigned EDGE_HI = 60,
  localparam int unsigned EW = $clog2(EDGE_HI + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic win_i,
  input  logic edge_i,
  input  logic close_i,
  output logic bit_o
);
  localparam logic [EW-1:0] CMAX = {EW{1'b1}};

  logic [EW-1:0] cnt_q, cnt_nxt;

  // includes an edge seen on the closing cycle itself
  assign cnt_nxt = (win_i && edge_i && cnt_q != CMAX) ? cnt_q + EW'(1) : cnt_q;
  assign bit_o   = (cnt_nxt > EW'(EDGE_LO)) && (cnt_nxt < EW'(EDGE_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || close_i)   cnt_q <= '0;
    else                         cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/sc_edge_rx.sv
module sc_edge_rx #(
  parameter int unsigned WAIT_TICKS = 490,
  parameter int unsigned BIT_TICKS  = 150,
  parameter int unsigned EDGE_LO    = 20,
  parameter int unsigned EDGE_HI    = 60,
  parameter int unsigned MAX_BITS   = 16,
  parameter int unsigned NB_IN_W    = 5,
  localparam int unsigned IW   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1,
  localparam int unsigned NO_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic [NB_IN_W-1:0]  nbits_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic [NO_W-1:0]     nbits_o,
  output logic                done_o,
  output logic                timer_clr_o
);
  logic            edge_w, win_w, close_w, fin_w, busy_w, bit_w;
  logic [IW-1:0]   idx_w;
  logic [NO_W-1:0] req_w;
  logic [MAX_BITS-1:0] data_q;
  logic [NO_W-1:0] nbits_q;
  logic            done_q;

  assign req_w = (int'(nbits_i) > int'(MAX_BITS)) ? NO_W'(MAX_BITS) : NO_W'(nbits_i);

  sc_rx_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .edge_o(edge_w)
  );

  sc_rx_timer #(
    .WAIT_TICKS(WAIT_TICKS),
    .BIT_TICKS (BIT_TICKS),
    .MAX_BITS  (MAX_BITS)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .start_i(start_i),
    .req_i  (req_w),
    .win_o  (win_w),
    .close_o(close_w),
    .fin_o  (fin_w),
    .busy_o (busy_w),
    .idx_o  (idx_w)
  );

  sc_rx_edge_cnt #(
    .EDGE_LO(EDGE_LO),
    .EDGE_HI(EDGE_HI)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .win_i  (win_w),
    .edge_i (edge_w),
    .close_i(close_w),
    .bit_o  (bit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      nbits_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_w;
      if (start_i) begin
        data_q  <= '0;
        nbits_q <= req_w;
      end else if (close_w) begin
        data_q[idx_w] <= bit_w;
      end
    end
  end

  assign data_o      = data_q;
  assign nbits_o     = nbits_q;
  assign done_o      = done_q;
  assign timer_clr_o = done_q;
endmodule

// File: rtl/sc_edge_rx_chk.sv
module sc_edge_rx_chk #(
  parameter int unsigned MAX_BITS = 16,
  localparam int unsigned NO_W = $clog2(MAX_BITS + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                busy_i,
  input logic [MAX_BITS-1:0] data_o,
  input logic [NO_W-1:0]     nbits_o,
  input logic                done_o
);
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(start_i)) |-> !busy_i);

  assert_nbits_clamped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(nbits_o) <= int'(MAX_BITS));

  assert_data_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (data_o == '0));

  assert_idle_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(data_o));
endmodule

bind sc_edge_rx sc_edge_rx_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_i (busy_w),
  .data_o (data_o),
  .nbits_o(nbits_o),
  .done_o (done_o)
);

// File: tb/sc_edge_rx_bench.sv
module sc_edge_rx_bench;
  localparam int W  = 20;
  localparam int B  = 16;
  localparam int LO = 2;
  localparam int HI = 7;
  localparam int MB = 16;
  localparam int SATV = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b0;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  nbits = '0;
  logic [15:0] data;
  logic [4:0]  nbits_q;
  logic        done, tclr;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  int pat [0:19];

  always #2.5 clk = ~clk;

  sc_edge_rx #(
    .WAIT_TICKS(W), .BIT_TICKS(B), .EDGE_LO(LO), .EDGE_HI(HI), .MAX_BITS(MB), .NB_IN_W(5)
  ) u_sc_edge_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .start_i(start),
    .nbits_i(nbits), .data_o(data), .nbits_o(nbits_q), .done_o(done), .timer_clr_o(tclr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int dec(input int e);
    int c = (e > SATV) ? SATV : e;
    return (c > LO && c < HI) ? 1 : 0;
  endfunction

  // one reception: pat[] holds edges per window, div sets tick spacing
  task automatic run_rx(input int req, input int div, input string tag);
    int eff   = (req > MB) ? MB : req;
    int total = div * (W + eff * B) + 1;
    int expd  = 0;
    int seen  = 0;
    int first = -1;
    for (int b = 0; b < eff; b++) expd |= dec(pat[b]) << b;
    @(negedge clk);
    start = 1'b1; nbits = 5'(req); tick = 1'b1;
    for (int k = 1; k <= total + 3; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == 1) begin
        chk(data == 16'h0, {tag, " R8 clear"}, data, 0);
        chk(int'(nbits_q) == eff, {tag, " R6 nbits"}, nbits_q, eff);
      end
      if (done) begin
        seen++;
        if (first < 0) first = k;
        chk(tclr == 1'b1, {tag, " R9 clr"}, tclr, 1);
        chk(data == 16'(expd), {tag, " R4 R5 data"}, data, expd);
      end
      tick = (k % div == 0);
      if (div == 1 && k > W) begin
        int r = k - W - 1;
        int b = r / B;
        int j = r % B;
        if (b < eff && j < pat[b]) rx = ~rx;
      end
    end
    tick = 1'b0;
    chk(first == total, {tag, " R2 R11 done time"}, first, total);
    chk(seen == 1, {tag, " R10 one pulse"}, seen, 1);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(data == 0 && nbits_q == 0 && !done && !tclr, "R1 reset", {done, tclr, data}, 0);
  endtask

  task automatic t_band;  // R3 R4 thresholds 2,3,6,7
    pat[0]=4; pat[1]=0; pat[2]=6; pat[3]=0; pat[4]=3; pat[5]=2; pat[6]=7; pat[7]=5;
    run_rx(8, 1, "band");
  endtask

  task automatic t_lsb;   // R5
    pat[0]=0; pat[1]=0; pat[2]=0; pat[3]=4;
    run_rx(4, 1, "lsb");
  endtask

  task automatic t_sat;   // R7 wrap would give 1s here
    pat[0]=12; pat[1]=13; pat[2]=4;
    run_rx(3, 1, "sat R7");
  endtask

  task automatic t_clamp; // R6
    for (int b = 0; b < 20; b++) pat[b] = (b % 2 == 0) ? 4 : 0;
    run_rx(20, 1, "clamp");
  endtask

  task automatic t_zero;  // R10
    run_rx(0, 1, "zero");
  endtask

  task automatic t_tick;  // R11
    for (int b = 0; b < 20; b++) pat[b] = 0;
    run_rx(2, 3, "tick");
  endtask

  initial begin
    for (int b = 0; b < 20; b++) pat[b] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_band();
    t_lsb();
    t_sat();
    t_clamp();
    t_zero();
    t_tick();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule